// File: doc/BRIEF.md
# Clock Source Switch Sequencer with Shared Watchdog Counter

This block selects which oscillator drives the system clock and sequences every change of source. Software writes an 8-bit control word that carries a requested source and an internal RC frequency code. The block answers with the source actually in use, the frequency code, a flag that says whether the core runs on the primary clock, and a flag that says whether the internal RC has settled at its current frequency. The clock mux itself and the oscillators are outside the block: it only produces the select codes and reads back ready and stable indications.

One counter does two jobs. While the core is running it is the watchdog, which produces a one-cycle reset pulse when software fails to clear it in time. While a change to a crystal or resonator primary mode is pending, the same counter counts cycles of the target oscillator as a start-up delay. The watchdog is therefore suspended for the length of a switch and always restarts from zero on the new clock. A two-speed boot option lets the core start on the internal RC and move to a crystal primary once its start-up delay has passed.

Top module: `osc_clock_switch`

## Requirements
- R1: `reg_rd_data` is {0, frequency code (bits 6:4), primary-running flag (bit 3), frequency-stable flag (bit 2), requested source (bits 1:0)}; after a reset with two-speed boot off it reads 0x08.
- R2: Source codes are 00 primary, 01 low-power secondary, 10 internal RC. A write of 00 (primary needing no start-up delay), 01 or 10 updates the requested source at the write edge, and `src_sel` follows on the next clock edge; bit 3 reads 1 exactly when `src_sel` is 00.
- R3: A written source code of 11 leaves both the requested and the active source unchanged, while the frequency field of the same write still takes effect.
- R4: `freq_sel` carries the written 3-bit frequency code (000 slowest at 31.25 kHz up to 111 at 8 MHz) from the write edge on.
- R5: The frequency-stable flag clears at any write whose frequency code differs from the held one, is not cleared by a write of the same code, and sets on the first edge at which `osc_stable` is high and no such change occurs.
- R6: With `prim_mode` 000, 001 or 010 (crystal or resonator modes), a request for source 00 enters a start-up phase (`switching` high) and `src_sel` becomes 00 on the edge of the OST_CYCLES-th `osc_tick`; with any other `prim_mode` the change completes on the next edge and `switching` stays low.
- R7: While `switching` is high, `wdt_clear` has no effect and `wdt_reset` stays low.
- R8: When a start-up phase completes, the counter restarts from zero: with no clear, `wdt_reset` pulses exactly WDT_LIMIT edges after the completing edge.
- R9: While running, `wdt_reset` is high for exactly one cycle, WDT_LIMIT edges after the last edge at which `wdt_clear` was sampled high or the last pulse.
- R10: When reset is released with `two_speed_en` high and a crystal `prim_mode`, the block starts on the internal RC (bit 3 reads 0, `src_sel` 10) with 00 requested, and enters the start-up phase on the first edge after reset.
- R11: A request for a source other than 00 during the start-up phase abandons it (`switching` falls one edge after the request is seen) and the new source is taken on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| two_speed_en | input | 1 | Boot on internal RC, then move to a crystal primary |
| prim_mode | input | 3 | Primary oscillator configuration code |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wr_data | input | 8 | Control word write data |
| osc_tick | input | 1 | One pulse per cycle of the target oscillator |
| osc_stable | input | 1 | Internal RC reports a settled frequency |
| wdt_clear | input | 1 | Software watchdog clear |
| reg_rd_data | output | 8 | Control word read data |
| src_sel | output | 2 | Active clock source code |
| freq_sel | output | 3 | Internal RC frequency code |
| run_primary | output | 1 | Core runs on the primary clock |
| freq_stable | output | 1 | Internal RC frequency settled |
| switching | output | 1 | Start-up phase in progress, watchdog suspended |
| wdt_reset | output | 1 | One-cycle watchdog timeout pulse |

## Verification
Two collisions matter. A watchdog clear held high through a start-up phase falls in the same cycles as the shared counter's start-up counting; the bench holds the clear there and judges it by the exact cycle of the completion edge and by the watchdog pulse landing exactly WDT_LIMIT edges after it. A frequency change written while `osc_stable` is already high falls in the same edge as the flag's set condition; the bench expects the flag low right after that write and high one edge later.

// File: rtl/osc_sel_pkg.sv
package osc_sel_pkg;
   typedef enum logic [1:0] {
      SRC_PRIMARY   = 2'b00,
      SRC_SECONDARY = 2'b01,
      SRC_INTRC     = 2'b10,
      SRC_RSVD      = 2'b11
   } src_e;

   typedef enum logic {
      PH_RUN     = 1'b0,
      PH_STARTUP = 1'b1
   } phase_e;

   localparam int CTRL_W = 8;
   localparam int FREQ_W = 3;
   localparam int MODE_W = 3;
endpackage

// File: rtl/osc_ctrl_reg.sv
module osc_ctrl_reg
   import osc_sel_pkg::*;
#(
   parameter int FW = FREQ_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [FW-1:0] wr_freq,
   input  src_e          wr_src,
   input  logic          osc_stable,
   output logic [FW-1:0] freq_code,
   output src_e          req_src,
   output logic          freq_stable
);
   generate
      if (FW < 1) begin : g_bad_fw
         $error("osc_ctrl_reg: FW must be at least 1");
      end
   endgenerate

   logic freq_change;
   assign freq_change = wr_en && (wr_freq != freq_code);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         freq_code   <= '0;
         req_src     <= SRC_PRIMARY;
         freq_stable <= 1'b0;
      end else begin
         if (wr_en) begin
            freq_code <= wr_freq;
            if (wr_src != SRC_RSVD) req_src <= wr_src;
         end
         if (freq_change)     freq_stable <= 1'b0;
         else if (osc_stable) freq_stable <= 1'b1;
      end
   end

   assert_rsvd_keeps_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_src == SRC_RSVD) |=> $stable(req_src));

   assert_freq_change_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_freq != freq_code) |=> !freq_stable);

   assert_no_rsvd_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_src != SRC_RSVD);
endmodule

// File: rtl/osc_shared_counter.sv
module osc_shared_counter #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [CW-1:0] count
);
   generate
      if (CW < 2) begin : g_bad_cw
         $error("osc_shared_counter: CW must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    count <= '0;
      else if (clr)  count <= '0;
      else if (inc)  count <= count + 1'b1;
   end

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc && !clr && count == '1));
endmodule

// File: rtl/osc_switch_fsm.sv
module osc_switch_fsm
   import osc_sel_pkg::*;
#(
   parameter int              CW         = 12,
   parameter int              OST_CYCLES = 1024,
   parameter int              WDT_LIMIT  = 4000,
   parameter logic [7:0]      XTAL_MASK  = 8'b0000_0111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_two_speed,
   input  logic [MODE_W-1:0] prim_mode,
   input  src_e              req_src,
   input  logic              osc_tick,
   input  logic              wdt_clear,
   input  logic [CW-1:0]     count,
   output logic              cnt_clr,
   output logic              cnt_inc,
   output src_e              cur_src,
   output logic              switching,
   output logic              wdt_reset
);
   localparam logic [CW-1:0] OST_LAST = CW'(OST_CYCLES - 1);
   localparam logic [CW-1:0] WDT_LAST = CW'(WDT_LIMIT - 1);

   generate
      if (OST_CYCLES < 1 || OST_CYCLES > (1 << CW)) begin : g_bad_ost
         $error("osc_switch_fsm: OST_CYCLES out of counter range");
      end
      if (WDT_LIMIT < 2 || WDT_LIMIT > (1 << CW)) begin : g_bad_wdt
         $error("osc_switch_fsm: WDT_LIMIT out of counter range");
      end
   endgenerate

   logic needs_ost;
   generate
      if (XTAL_MASK == 8'd0) begin : g_no_xtal
         logic [MODE_W-1:0] unused_mode;
         assign unused_mode = prim_mode;
         assign needs_ost   = 1'b0;
      end else begin : g_xtal
         assign needs_ost = XTAL_MASK[prim_mode];
      end
   endgenerate

   phase_e phase, nxt_phase;
   src_e   nxt_src;
   logic   bite;

   always_comb begin
      cnt_clr   = 1'b0;
      cnt_inc   = 1'b0;
      bite      = 1'b0;
      nxt_phase = phase;
      nxt_src   = cur_src;
      case (phase)
         PH_RUN: begin
            if (req_src != cur_src) begin
               cnt_clr = 1'b1;
               if (req_src == SRC_PRIMARY && needs_ost) nxt_phase = PH_STARTUP;
               else                                     nxt_src   = req_src;
            end else if (wdt_clear) begin
               cnt_clr = 1'b1;
            end else if (count == WDT_LAST) begin
               cnt_clr = 1'b1;
               bite    = 1'b1;
            end else begin
               cnt_inc = 1'b1;
            end
         end
         PH_STARTUP: begin
            if (req_src != SRC_PRIMARY) begin
               cnt_clr   = 1'b1;
               nxt_phase = PH_RUN;
            end else if (osc_tick) begin
               if (count == OST_LAST) begin
                  cnt_clr   = 1'b1;
                  nxt_src   = SRC_PRIMARY;
                  nxt_phase = PH_RUN;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
         end
         default: nxt_phase = PH_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_RUN;
         cur_src   <= (boot_two_speed && needs_ost) ? SRC_INTRC : SRC_PRIMARY;
         wdt_reset <= 1'b0;
      end else begin
         phase     <= nxt_phase;
         cur_src   <= nxt_src;
         wdt_reset <= bite;
      end
   end

   assign switching = (phase == PH_STARTUP);

   assert_quiet_in_startup_R7: assert property (@(posedge clk) disable iff (!rst_n)
      switching |=> !wdt_reset);

   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_reset |=> !wdt_reset);

   assert_restart_from_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(switching) |-> (count == '0));

   assert_valid_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cur_src != SRC_RSVD);

   assert_abort_leaves_startup_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (switching && req_src != SRC_PRIMARY) |=> !switching);
endmodule

// File: rtl/osc_clock_switch.sv
module osc_clock_switch
   import osc_sel_pkg::*;
#(
   parameter int         CNT_W      = 12,
   parameter int         OST_CYCLES = 1024,
   parameter int         WDT_LIMIT  = 4000,
   parameter logic [7:0] XTAL_MASK  = 8'b0000_0111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              two_speed_en,
   input  logic [MODE_W-1:0] prim_mode,
   input  logic              reg_wr_en,
   input  logic [CTRL_W-1:0] reg_wr_data,
   input  logic              osc_tick,
   input  logic              osc_stable,
   input  logic              wdt_clear,
   output logic [CTRL_W-1:0] reg_rd_data,
   output logic [1:0]        src_sel,
   output logic [FREQ_W-1:0] freq_sel,
   output logic              run_primary,
   output logic              freq_stable,
   output logic              switching,
   output logic              wdt_reset
);
   src_e             req_src, cur_src;
   logic [CNT_W-1:0] count;
   logic             cnt_clr, cnt_inc;
   logic             unused_wr_bits;

   assign unused_wr_bits = ^{reg_wr_data[7], reg_wr_data[3:2]};

   osc_ctrl_reg #(.FW(FREQ_W)) u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (reg_wr_en),
      .wr_freq     (reg_wr_data[6:4]),
      .wr_src      (src_e'(reg_wr_data[1:0])),
      .osc_stable  (osc_stable),
      .freq_code   (freq_sel),
      .req_src     (req_src),
      .freq_stable (freq_stable)
   );

   osc_shared_counter #(.CW(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .count (count)
   );

   osc_switch_fsm #(
      .CW         (CNT_W),
      .OST_CYCLES (OST_CYCLES),
      .WDT_LIMIT  (WDT_LIMIT),
      .XTAL_MASK  (XTAL_MASK)
   ) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .boot_two_speed (two_speed_en),
      .prim_mode      (prim_mode),
      .req_src        (req_src),
      .osc_tick       (osc_tick),
      .wdt_clear      (wdt_clear),
      .count          (count),
      .cnt_clr        (cnt_clr),
      .cnt_inc        (cnt_inc),
      .cur_src        (cur_src),
      .switching      (switching),
      .wdt_reset      (wdt_reset)
   );

   assign src_sel     = cur_src;
   assign run_primary = (cur_src == SRC_PRIMARY);
   assign reg_rd_data = {1'b0, freq_sel, run_primary, freq_stable, req_src};

   assert_readback_layout_R1: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_data[7] == 1'b0 && reg_rd_data[3] == (src_sel == 2'b00));
endmodule

// File: tb/osc_clock_switch_tb.sv
module osc_clock_switch_tb;
   localparam int OST = 64;
   localparam int LIM = 300;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       two_speed_en = 1'b0;
   logic [2:0] prim_mode = 3'b001;
   logic       reg_wr_en = 1'b0;
   logic [7:0] reg_wr_data = 8'h00;
   logic       osc_tick = 1'b0;
   logic       osc_stable = 1'b0;
   logic       wdt_clear = 1'b0;
   logic [7:0] reg_rd_data;
   logic [1:0] src_sel;
   logic [2:0] freq_sel;
   logic       run_primary, freq_stable, switching, wdt_reset;

   always #2 clk = ~clk;

   osc_clock_switch #(.CNT_W(10), .OST_CYCLES(OST), .WDT_LIMIT(LIM)) u_dut (
      .clk(clk), .rst_n(rst_n), .two_speed_en(two_speed_en), .prim_mode(prim_mode),
      .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .osc_tick(osc_tick),
      .osc_stable(osc_stable), .wdt_clear(wdt_clear), .reg_rd_data(reg_rd_data),
      .src_sel(src_sel), .freq_sel(freq_sel), .run_primary(run_primary),
      .freq_stable(freq_stable), .switching(switching), .wdt_reset(wdt_reset)
   );

   typedef enum int {S_RD, S_SRC, S_FREQ, S_WDT, S_SW, S_STB} sel_e;
   typedef struct { int due; sel_e sel; int val; string tag; } exp_t;
   exp_t q[$];
   int cyc = 0;
   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;

   always @(posedge clk) cyc++;

   function automatic int observe(sel_e s);
      case (s)
         S_RD:   return int'(reg_rd_data);
         S_SRC:  return int'(src_sel);
         S_FREQ: return int'(freq_sel);
         S_WDT:  return int'(wdt_reset);
         S_SW:   return int'(switching);
         default: return int'(freq_stable);
      endcase
   endfunction

   task automatic expect_at(sel_e s, int val, int dly, string tag);
      exp_t e;
      e.due = cyc + dly; e.sel = s; e.val = val; e.tag = tag;
      q.push_back(e);
   endtask

   initial begin
      forever begin
         @(negedge clk);
         #1;
         for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due <= cyc) begin
               int act;
               act = observe(q[i].sel);
               n_checks++;
               if (act !== q[i].val) begin
                  n_fail++;
                  $display("FAIL %s sel=%0d cycle=%0d actual=0x%0h expected=0x%0h",
                           q[i].tag, q[i].sel, cyc, act, q[i].val);
               end
               q.delete(i);
            end
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_ctrl(logic [7:0] d);
      reg_wr_en = 1'b1; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic do_reset(logic ts, logic [2:0] pm);
      rst_n = 1'b0; two_speed_en = ts; prim_mode = pm;
      step(3);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      // reset, primary XT, two-speed off
      do_reset(1'b0, 3'b001);
      expect_at(S_RD, 8'h08, 0, "R1 reset value");
      expect_at(S_SRC, 0, 0, "R2 reset source");
      expect_at(S_SW, 0, 0, "R7 no switch after reset");

      // to internal RC at 4 MHz code
      write_ctrl(8'h62);
      expect_at(S_RD, 8'h6A, 0, "R1 readback before source change");
      expect_at(S_SRC, 0, 0, "R2 source not yet changed");
      expect_at(S_FREQ, 6, 0, "R4 freq code");
      expect_at(S_SRC, 2, 1, "R2 internal RC taken");
      expect_at(S_RD, 8'h62, 1, "R1 status bit cleared off primary");
      step(2);

      // stable flag behaviour
      osc_stable = 1'b1;
      expect_at(S_STB, 1, 1, "R5 stable sets");
      step(2);
      write_ctrl(8'h62);
      expect_at(S_STB, 1, 0, "R5 same code keeps stable");
      write_ctrl(8'h72);
      expect_at(S_STB, 0, 0, "R5 change wins over stable input");
      expect_at(S_FREQ, 7, 0, "R4 freq code 7");
      expect_at(S_STB, 1, 1, "R5 stable sets again");
      step(2);

      // reserved source code
      write_ctrl(8'h13);
      expect_at(S_RD, 8'h12, 0, "R3 reserved keeps request, freq written");
      expect_at(S_SRC, 2, 1, "R3 active source kept");
      expect_at(S_SRC, 2, 2, "R3 active source still kept");
      expect_at(S_RD, 8'h16, 1, "R3 readback after settle");
      step(3);

      // to secondary
      write_ctrl(8'h11);
      expect_at(S_SRC, 1, 1, "R2 secondary taken");
      step(2);

      // to primary crystal: start-up phase, clears ignored
      write_ctrl(8'h10);
      expect_at(S_SW, 1, 1, "R6 start-up entered");
      expect_at(S_SRC, 1, 1, "R6 source held during start-up");
      step(1);
      wdt_clear = 1'b1;
      expect_at(S_WDT, 0, 1, "R7 no pulse during start-up");
      step(5);
      expect_at(S_SRC, 1, 0, "R6 no ticks no change");
      osc_tick = 1'b1;
      step(OST - 1);
      expect_at(S_SRC, 1, 0, "R6 one tick short");
      expect_at(S_SW, 1, 0, "R7 still suspended");
      step(1);
      osc_tick = 1'b0;
      wdt_clear = 1'b0;
      expect_at(S_SRC, 0, 0, "R6 primary after start-up");
      expect_at(S_SW, 0, 0, "R6 start-up done");
      expect_at(S_RD, 8'h1C, 0, "R1 status set on primary");
      expect_at(S_WDT, 0, LIM - 1, "R8 no early pulse");
      expect_at(S_WDT, 1, LIM, "R8 pulse after restart");
      expect_at(S_WDT, 0, LIM + 1, "R9 pulse one cycle");
      step(LIM + 2);

      // clear restarts the watchdog
      wdt_clear = 1'b1;
      step(1);
      wdt_clear = 1'b0;
      step(150);
      wdt_clear = 1'b1;
      step(1);
      wdt_clear = 1'b0;
      expect_at(S_WDT, 0, LIM - 151, "R9 earlier deadline cancelled");
      expect_at(S_WDT, 0, LIM - 1, "R9 no early pulse");
      expect_at(S_WDT, 1, LIM, "R9 pulse after clear");
      expect_at(S_WDT, 0, LIM + 1, "R9 single cycle");
      step(LIM + 2);

      // abort a start-up phase
      write_ctrl(8'h12);
      expect_at(S_SRC, 2, 1, "R2 internal RC again");
      step(2);
      write_ctrl(8'h10);
      step(1);
      expect_at(S_SW, 1, 0, "R11 start-up running");
      write_ctrl(8'h11);
      expect_at(S_SW, 0, 1, "R11 start-up abandoned");
      expect_at(S_SRC, 2, 1, "R11 old source held");
      expect_at(S_SRC, 1, 2, "R11 new source taken");
      step(3);

      // non-crystal primary skips start-up
      prim_mode = 3'b100;
      step(1);
      write_ctrl(8'h10);
      expect_at(S_SW, 0, 0, "R6 no start-up for non-crystal");
      expect_at(S_SW, 0, 1, "R6 still no start-up");
      expect_at(S_SRC, 0, 1, "R6 immediate primary");
      expect_at(S_RD, 8'h1C, 1, "R1 readback on primary");
      step(3);

      // two-speed boot with HS crystal
      osc_stable = 1'b0;
      do_reset(1'b1, 3'b010);
      expect_at(S_RD, 8'h00, 0, "R10 boot status clear");
      expect_at(S_SRC, 2, 0, "R10 boot on internal RC");
      expect_at(S_SW, 1, 1, "R10 start-up after reset");
      step(1);
      osc_tick = 1'b1;
      step(OST - 1);
      expect_at(S_SRC, 2, 0, "R10 still internal RC");
      step(1);
      osc_tick = 1'b0;
      expect_at(S_SRC, 0, 0, "R10 primary reached");
      expect_at(S_RD, 8'h08, 0, "R10 status set");
      step(2);

      while (q.size() != 0) step(1);
      done = 1;
      finish_run();
   end
endmodule